// File: doc/BRIEF.md
# Fault-Aware Mesh Route Unit

This block computes the output direction set for one packet header in a router of a two-dimensional mesh. It takes the header fields (destination X and Y, a dimension-order mode bit and a small lifetime count) together with the router's own coordinates, the input port the header arrived on, and a static mask of neighbours that were found unusable at boot. It returns a multi-hot output port vector and the updated header fields, held in one output register with a valid/ready handshake.

Healthy traffic follows plain dimension-order routing. If the preferred neighbour is masked, the block picks a second-choice direction instead. If that one is masked as well, it copies the header to every usable neighbour except the one it came from. Each hop that leaves the proper path costs one unit of lifetime. A sideways step in X flips the header to Y-first mode, so the next router does not send the packet straight back. Once a proper hop is possible the mode returns to X-first. A packet that has no lifetime left is dropped when it would need a detour. Crossbar, buffering, arbitration, flow control and the boot-time neighbour probing are outside this block.

Top module: `noc_fault_router`

## Requirements
- R1: Port vector bits are 0 local, 1 north (+Y), 2 east (+X), 3 south (-Y), 4 west (-X). With `in_ymode`=0 and a usable preferred neighbour, the packet goes east or west while its X differs from `my_x`, and north or south otherwise. The lifetime is unchanged and `out_ymode` is 0.
- R2: With `in_ymode`=1, the preferred direction is north or south while Y differs, and east or west otherwise. A proper hop in this mode clears `out_ymode` to 0.
- R3: When the destination equals (`my_x`,`my_y`), only bit 0 is set. The lifetime is unchanged, `out_ymode` is 0 and `out_drop` is 0.
- R4: `fault_mask` bit k masks port k+1. If the preferred port is masked, the second choice is taken. When both dimensions still differ, the second choice is the other dimension's productive direction. When one dimension is already aligned, it is north if the preferred move is in X, and east if the preferred move is in Y.
- R5: If both the preferred and second-choice ports are masked, the vector holds every unmasked neighbour (bits 1-4) except the arrival port given by `in_port` (0 to 4). It never holds bit 0.
- R6: A second-choice or broadcast hop outputs the lifetime minus one.
- R7: A second-choice hop east or west, or a broadcast that includes east or west, sets `out_ymode` to 1. A detour made only north or south passes `in_ymode` through unchanged.
- R8: A packet is dropped when its lifetime is 0 and it would need a detour, or when a broadcast would select no port. A dropped packet gives `out_drop`=1, a zero port vector, and the lifetime and mode unchanged.
- R9: `in_ready` is high when the output register is empty or `out_ready` is high. While `out_valid` is high and `out_ready` is low, every output field is held steady.
- R10: After reset `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Header present |
| in_ready | output | 1 | Header accepted this cycle when high with in_valid |
| in_dst_x | input | COORD_W | Destination X |
| in_dst_y | input | COORD_W | Destination Y |
| in_ymode | input | 1 | 1 = route Y first |
| in_life | input | LIFE_W | Remaining detour budget |
| in_port | input | 3 | Arrival port index, 0 to 4 |
| my_x | input | COORD_W | Router X coordinate |
| my_y | input | COORD_W | Router Y coordinate |
| fault_mask | input | 4 | Bit k = neighbour on port k+1 unusable |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_ports | output | 5 | Selected output ports, multi-hot |
| out_ymode | output | 1 | Updated mode bit |
| out_life | output | LIFE_W | Updated lifetime |
| out_drop | output | 1 | Packet discarded |

## Verification
The bench targets the aligned-dimension cases. There, a design that chose the wrong perpendicular direction would send a packet away from the lowest-index port. It also drives broadcasts arriving on a usable port. A design that failed to exclude the arrival port would bounce copies straight back. It mixes lifetime-zero headers with masked ports to catch a design that still forwards, or that wraps the lifetime to its maximum. It checks mode handling after east/west detours, where a wrong bit would let the next router backtrack. It also checks proper hops, where a stuck bit would keep the packet in Y-first mode. Random stalls on `out_ready` expose a design that changes or loses a held result.

// File: rtl/noc_route_pkg.sv
package noc_route_pkg;
    localparam int PORT_N  = 5;
    localparam int NBR_N   = PORT_N - 1;
    localparam int P_LOCAL = 0;
    localparam int P_NORTH = 1;
    localparam int P_EAST  = 2;
    localparam int P_SOUTH = 3;
    localparam int P_WEST  = 4;
    localparam int PIDX_W  = 3;

    typedef logic [PORT_N-1:0] port_vec_t;

    localparam port_vec_t OH_LOCAL = port_vec_t'(1) << P_LOCAL;
    localparam port_vec_t OH_NORTH = port_vec_t'(1) << P_NORTH;
    localparam port_vec_t OH_EAST  = port_vec_t'(1) << P_EAST;
    localparam port_vec_t OH_SOUTH = port_vec_t'(1) << P_SOUTH;
    localparam port_vec_t OH_WEST  = port_vec_t'(1) << P_WEST;
    localparam port_vec_t OH_XDIM  = OH_EAST | OH_WEST;
endpackage

// File: rtl/xy_dir_pick.sv
module xy_dir_pick
    import noc_route_pkg::*;
#(
    parameter int COORD_W = 4
) (
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    input  logic [COORD_W-1:0] here_x,
    input  logic [COORD_W-1:0] here_y,
    input  logic               ymode,
    output logic               at_home,
    output port_vec_t          pref_oh,
    output port_vec_t          alt_oh,
    output logic               alt_is_x
);
    logic      x_pos, x_neg, y_pos, y_neg;
    logic      x_need, y_need, pref_x;
    port_vec_t x_oh, y_oh;

    always_comb begin
        x_pos   = dst_x > here_x;
        x_neg   = dst_x < here_x;
        y_pos   = dst_y > here_y;
        y_neg   = dst_y < here_y;
        x_need  = x_pos | x_neg;
        y_need  = y_pos | y_neg;
        at_home = !x_need && !y_need;

        x_oh = '0;
        y_oh = '0;
        x_oh[P_EAST]  = x_pos;
        x_oh[P_WEST]  = x_neg;
        y_oh[P_NORTH] = y_pos;
        y_oh[P_SOUTH] = y_neg;

        // dimension preferred by the header's mode
        pref_x  = ymode ? !y_need : x_need;
        pref_oh = pref_x ? x_oh : y_oh;

        // second choice: other productive dimension, else lowest perpendicular
        if (pref_x) begin
            alt_oh = y_need ? y_oh : OH_NORTH;
        end else begin
            alt_oh = x_need ? x_oh : OH_EAST;
        end
        alt_is_x = !pref_x;
    end
endmodule

// File: rtl/fault_resolver.sv
module fault_resolver
    import noc_route_pkg::*;
#(
    parameter int LIFE_W = 2
) (
    input  logic              at_home,
    input  port_vec_t         pref_oh,
    input  port_vec_t         alt_oh,
    input  logic              alt_is_x,
    input  logic [NBR_N-1:0]  fault_mask,
    input  logic [PIDX_W-1:0] arr_port,
    input  logic [LIFE_W-1:0] life_i,
    input  logic              ymode_i,
    output port_vec_t         ports_o,
    output logic              ymode_o,
    output logic [LIFE_W-1:0] life_o,
    output logic              drop_o
);
    port_vec_t avail;
    port_vec_t arr_oh;
    port_vec_t spray;
    logic      pref_ok, alt_ok;

    for (genvar k = 0; k < PORT_N; k++) begin : g_port
        if (k == P_LOCAL) begin : g_loc
            assign avail[k] = 1'b1;
        end else begin : g_nbr
            assign avail[k] = ~fault_mask[k-1];
        end
        assign arr_oh[k] = (arr_port == PIDX_W'(k));
    end

    assign spray   = avail & ~arr_oh & ~OH_LOCAL;
    assign pref_ok = |(pref_oh & avail);
    assign alt_ok  = |(alt_oh & avail);

    always_comb begin
        ports_o = '0;
        ymode_o = ymode_i;
        life_o  = life_i;
        drop_o  = 1'b0;
        if (at_home) begin
            ports_o = OH_LOCAL;
            ymode_o = 1'b0;
        end else if (pref_ok) begin
            ports_o = pref_oh;
            ymode_o = 1'b0;
        end else if (life_i == '0) begin
            drop_o = 1'b1;
        end else if (alt_ok) begin
            ports_o = alt_oh;
            life_o  = life_i - 1'b1;
            if (alt_is_x) ymode_o = 1'b1;
        end else if (spray == '0) begin
            drop_o = 1'b1;
        end else begin
            ports_o = spray;
            life_o  = life_i - 1'b1;
            if (|(spray & OH_XDIM)) ymode_o = 1'b1;
        end
    end
endmodule

// File: rtl/noc_fault_router.sv
module noc_fault_router
    import noc_route_pkg::*;
#(
    parameter int COORD_W = 4,
    parameter int LIFE_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [COORD_W-1:0] in_dst_x,
    input  logic [COORD_W-1:0] in_dst_y,
    input  logic               in_ymode,
    input  logic [LIFE_W-1:0]  in_life,
    input  logic [2:0]         in_port,
    input  logic [COORD_W-1:0] my_x,
    input  logic [COORD_W-1:0] my_y,
    input  logic [3:0]         fault_mask,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [4:0]         out_ports,
    output logic               out_ymode,
    output logic [LIFE_W-1:0]  out_life,
    output logic               out_drop
);
    typedef struct packed {
        logic              valid;
        port_vec_t         ports;
        logic              ymode;
        logic [LIFE_W-1:0] life;
        logic              drop;
    } out_reg_t;

    out_reg_t          r_d, r_q;
    logic              at_home, alt_is_x;
    port_vec_t         pref_oh, alt_oh, res_ports;
    logic              res_ymode, res_drop;
    logic [LIFE_W-1:0] res_life;

    xy_dir_pick #(.COORD_W(COORD_W)) u_pick (
        .dst_x    (in_dst_x),
        .dst_y    (in_dst_y),
        .here_x   (my_x),
        .here_y   (my_y),
        .ymode    (in_ymode),
        .at_home  (at_home),
        .pref_oh  (pref_oh),
        .alt_oh   (alt_oh),
        .alt_is_x (alt_is_x)
    );

    fault_resolver #(.LIFE_W(LIFE_W)) u_resolve (
        .at_home    (at_home),
        .pref_oh    (pref_oh),
        .alt_oh     (alt_oh),
        .alt_is_x   (alt_is_x),
        .fault_mask (fault_mask),
        .arr_port   (in_port),
        .life_i     (in_life),
        .ymode_i    (in_ymode),
        .ports_o    (res_ports),
        .ymode_o    (res_ymode),
        .life_o     (res_life),
        .drop_o     (res_drop)
    );

    always_comb begin
        r_d      = r_q;
        in_ready = !r_q.valid || out_ready;
        if (out_ready) r_d.valid = 1'b0;
        if (in_valid && in_ready) begin
            r_d.valid = 1'b1;
            r_d.ports = res_ports;
            r_d.ymode = res_ymode;
            r_d.life  = res_life;
            r_d.drop  = res_drop;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign out_valid = r_q.valid;
    assign out_ports = r_q.ports;
    assign out_ymode = r_q.ymode;
    assign out_life  = r_q.life;
    assign out_drop  = r_q.drop;
endmodule

// File: rtl/noc_fault_router_chk.sv
module noc_fault_router_chk #(
    parameter int LIFE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [LIFE_W-1:0] in_life,
    input logic [2:0]        in_port,
    input logic [3:0]        fault_mask,
    input logic              out_valid,
    input logic              out_ready,
    input logic [4:0]        out_ports,
    input logic              out_ymode,
    input logic [LIFE_W-1:0] out_life,
    input logic              out_drop
);
    logic [3:0]        cap_mask;
    logic [4:0]        cap_arr;
    logic [LIFE_W-1:0] cap_life;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_mask <= '0;
            cap_arr  <= '0;
            cap_life <= '0;
        end else if (in_valid && in_ready) begin
            cap_mask <= fault_mask;
            cap_arr  <= 5'b00001 << in_port;
            cap_life <= in_life;
        end
    end

    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_ports) && $stable(out_ymode)
                                    && $stable(out_life) && $stable(out_drop));
    a_r9_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);
    a_r8_drop_no_ports: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_drop |-> out_ports == 5'b0);
    a_r8_live_has_port: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_drop |-> out_ports != 5'b0);
    a_r3_local_alone: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ports[0] |-> out_ports == 5'b00001);
    a_r4_avoid_masked: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_ports[4:1] & cap_mask) == 4'b0);
    a_r5_no_bounce: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $countones(out_ports) > 1 |-> (out_ports & cap_arr) == 5'b0);
    a_r6_life_step: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_life == cap_life || out_life == LIFE_W'(cap_life - 1'b1));
endmodule

bind noc_fault_router noc_fault_router_chk #(.LIFE_W(LIFE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_life    (in_life),
    .in_port    (in_port),
    .fault_mask (fault_mask),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_ports  (out_ports),
    .out_ymode  (out_ymode),
    .out_life   (out_life),
    .out_drop   (out_drop)
);

// File: tb/tb_noc_fault_router.sv
`timescale 1ns/1ps
module tb_noc_fault_router;
    localparam int CW = 4;
    localparam int LW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [CW-1:0] in_dst_x = '0, in_dst_y = '0, my_x = '0, my_y = '0;
    logic          in_ymode = 1'b0;
    logic [LW-1:0] in_life = '0;
    logic [2:0]    in_port = '0;
    logic [3:0]    fault_mask = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [4:0]    out_ports;
    logic          out_ymode;
    logic [LW-1:0] out_life;
    logic          out_drop;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 0;

    bit [4:0] q_ports[$];
    bit       q_ym[$];
    int       q_life[$];
    bit       q_drop[$];
    string    q_tag[$];
    bit       q_lifechg[$];

    always #4 clk = ~clk;

    noc_fault_router #(.COORD_W(CW), .LIFE_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_dst_x(in_dst_x), .in_dst_y(in_dst_y), .in_ymode(in_ymode), .in_life(in_life),
        .in_port(in_port), .my_x(my_x), .my_y(my_y), .fault_mask(fault_mask),
        .out_valid(out_valid), .out_ready(out_ready), .out_ports(out_ports),
        .out_ymode(out_ymode), .out_life(out_life), .out_drop(out_drop)
    );

    task automatic chk(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // behavioural reference: returns ports, mode, lifetime, drop and a requirement tag
    task automatic model(input int dx_, input int dy_, input int mx, input int myy,
                         input bit ym, input int life, input int arr, input bit [3:0] fm,
                         output bit [4:0] p, output bit oym, output int ol,
                         output bit dr, output string tag);
        int xd, yd, pref, alt;
        bit pref_is_x;
        bit [4:0] bc;
        p = 0; oym = ym; ol = life; dr = 0;
        xd = (dx_ > mx) ? 2 : (dx_ < mx) ? 4 : 0;
        yd = (dy_ > myy) ? 1 : (dy_ < myy) ? 3 : 0;
        if (xd == 0 && yd == 0) begin
            p = 5'b00001; oym = 0; tag = "R3"; return;
        end
        if (ym) pref = (yd != 0) ? yd : xd;
        else    pref = (xd != 0) ? xd : yd;
        pref_is_x = (pref == 2 || pref == 4);
        if (pref_is_x) alt = (yd != 0) ? yd : 1;
        else           alt = (xd != 0) ? xd : 2;
        if (!fm[pref-1]) begin
            p[pref] = 1; oym = 0; tag = ym ? "R2" : "R1"; return;
        end
        if (life == 0) begin dr = 1; tag = "R8"; return; end
        if (!fm[alt-1]) begin
            p[alt] = 1; ol = life - 1; tag = "R4";
            if (alt == 2 || alt == 4) oym = 1;
            return;
        end
        bc = 0;
        for (int k = 1; k <= 4; k++) if (!fm[k-1] && k != arr) bc[k] = 1;
        if (bc == 0) begin dr = 1; tag = "R8"; return; end
        p = bc; ol = life - 1; tag = "R5";
        if (bc[2] || bc[4]) oym = 1;
    endtask

    task automatic step(input bit v, input int dx_, input int dy_, input bit ym,
                        input int life, input int arr, input int mx, input int myy,
                        input bit [3:0] fm, input bit rdy);
        bit acc;
        bit [4:0] p; bit oym; int ol; bit dr; string tag;
        @(negedge clk);
        in_valid = v; in_dst_x = CW'(dx_); in_dst_y = CW'(dy_); in_ymode = ym;
        in_life = LW'(life); in_port = 3'(arr); my_x = CW'(mx); my_y = CW'(myy);
        fault_mask = fm; out_ready = rdy;
        #1;
        chk("R9", "in_ready", int'(in_ready), int'(q_ports.size() == 0 || rdy));
        acc = v && in_ready;
        if (q_ports.size() > 0 && rdy) begin
            void'(q_ports.pop_front()); void'(q_ym.pop_front()); void'(q_life.pop_front());
            void'(q_drop.pop_front()); void'(q_tag.pop_front()); void'(q_lifechg.pop_front());
        end
        if (acc) begin
            model(dx_, dy_, mx, myy, ym, life, arr, fm, p, oym, ol, dr, tag);
            q_ports.push_back(p); q_ym.push_back(oym); q_life.push_back(ol);
            q_drop.push_back(dr); q_tag.push_back(tag); q_lifechg.push_back(ol != life);
        end
        @(posedge clk);
        #1;
        chk("R9", "out_valid", int'(out_valid), int'(q_ports.size() > 0));
        if (q_ports.size() > 0 && out_valid) begin
            chk(q_tag[0], "out_ports", int'(out_ports), int'(q_ports[0]));
            chk(q_tag[0] == "R8" ? "R8" : "R7", "out_ymode", int'(out_ymode), int'(q_ym[0]));
            chk(q_lifechg[0] ? "R6" : q_tag[0], "out_life", int'(out_life), q_life[0]);
            chk(q_tag[0] == "R8" ? "R8" : q_tag[0], "out_drop", int'(out_drop), int'(q_drop[0]));
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R10", "out_valid after reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R10", "out_valid idle", int'(out_valid), 0);

        // directed cases around router (5,5)
        step(1, 5, 5, 0, 2, 0, 5, 5, 4'b0000, 1);  // R3 local
        step(1, 8, 2, 0, 2, 0, 5, 5, 4'b0000, 1);  // R1 east first
        step(1, 5, 9, 0, 2, 0, 5, 5, 4'b0000, 1);  // R1 north when X aligned
        step(1, 8, 9, 1, 2, 0, 5, 5, 4'b0000, 1);  // R2 Y first, mode cleared
        step(1, 8, 9, 0, 2, 0, 5, 5, 4'b0010, 1);  // R4 east masked -> north, R6
        step(1, 5, 9, 0, 2, 3, 5, 5, 4'b0001, 1);  // R4 north masked -> east, R7
        step(1, 8, 5, 0, 3, 0, 5, 5, 4'b0010, 1);  // R4 aligned Y -> north
        step(1, 5, 1, 1, 2, 0, 5, 5, 4'b0110, 1);  // R4 south+east masked, aligned -> ...
        step(1, 2, 5, 0, 2, 2, 5, 5, 4'b1001, 1);  // R5 arrive east, only south left
        step(1, 2, 9, 0, 3, 0, 5, 5, 4'b1001, 1);  // R5 spray east+south, R7
        step(1, 8, 5, 0, 0, 0, 5, 5, 4'b0010, 1);  // R8 lifetime zero
        step(1, 8, 5, 0, 2, 0, 5, 5, 4'b1111, 1);  // R8 all masked
        step(1, 8, 5, 0, 2, 4, 5, 5, 4'b0111, 1);  // R8 only arrival port usable
        step(1, 9, 9, 1, 1, 0, 5, 5, 4'b0001, 1);  // R7 ymode=1, north masked -> east
        step(1, 5, 2, 1, 2, 0, 5, 5, 4'b0100, 1);  // R7 south masked, aligned -> east
        // R9 stall: hold result for several cycles
        step(1, 0, 0, 0, 2, 0, 5, 5, 4'b0000, 0);
        step(1, 9, 0, 0, 2, 0, 5, 5, 4'b0000, 0);
        step(0, 0, 0, 0, 0, 0, 5, 5, 4'b0000, 0);
        step(0, 0, 0, 0, 0, 0, 5, 5, 4'b0000, 1);
        step(0, 0, 0, 0, 0, 0, 5, 5, 4'b0000, 1);

        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 4) != 0, $urandom % 16, $urandom % 16, $urandom % 2,
                 $urandom % 4, $urandom % 5, $urandom % 16, $urandom % 16,
                 4'($urandom % 16), ($urandom % 3) != 0);
        end
        step(0, 0, 0, 0, 0, 0, 5, 5, 4'b0000, 1);
        step(0, 0, 0, 0, 0, 0, 5, 5, 4'b0000, 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule